// File: doc/BRIEF.md
# ALU Status Flag Generator

This block is a 16-bit arithmetic and logic unit that can also run on the low byte lane. It adds, subtracts, compares, ANDs and ORs two operands. Each executed operation writes a registered result and a set of six registered status flags: carry, even parity, auxiliary carry, zero, sign and signed overflow. The same flag register also keeps three control flags: single-step trap, interrupt enable and string direction. Each control flag has its own set and clear command, and no arithmetic or logic operation changes them.

A processor core presents both operands, a 3-bit operation code, a byte/word select and an execute strobe in one cycle. The result and the flags can be read from the next cycle on. A compare runs the subtraction for its flags only and leaves the result register as it was. Control-flag commands arrive on their own 3-bit command input. A command and an operation may be issued in the same cycle.

Top module: `alu_flag_unit`

## Requirements
- R1: With `execEn` high and `opSel` = 0 (add), the next cycle shows `result` = (A + B) modulo 2^n, where n is 8 in byte mode and 16 otherwise. `flags[0]` (carry) is set exactly when the sum reaches 2^n, so 255 + 1 in byte mode gives result 0 with carry set.
- R2: With `opSel` = 1 (subtract), `result` = (A − B) modulo 2^n. Carry is set exactly when A < B as unsigned numbers, which is a borrow.
- R3: With `opSel` = 2 (compare), the flags are updated exactly as for a subtract and `result` keeps its previous value.
- R4: `opSel` = 3 gives bitwise AND and `opSel` = 4 gives bitwise OR. Both clear carry (`flags[0]`), auxiliary carry (`flags[2]`) and overflow (`flags[5]`).
- R5: `flags[3]` (zero) is set when the n-bit result is 0, so 3 − 3 sets it. `flags[4]` (sign) equals bit n−1 of the result.
- R6: `flags[1]` (parity) is set when the low 8 bits of the result hold an even number of ones. This holds in word mode too.
- R7: `flags[2]` (auxiliary carry) is set when an add carries out of bit 3 into bit 4. For subtract and compare it is set when a borrow is taken from bit 4 into bit 3, which happens when A[3:0] < B[3:0].
- R8: `flags[5]` (overflow) is set when the signed n-bit result lies outside the signed n-bit range. For add this means both operands have the same sign and the result sign differs. For subtract it means the operand signs differ and the result sign differs from A.
- R9: In byte mode (`byteMode` = 1), operand bits above bit 7 are ignored and `result` bits 15..8 are written as 0.
- R10: `ctlCmd` values: 1 clears and 2 sets interrupt enable (`flags[7]`), 3 clears and 4 sets trap (`flags[6]`), 5 clears and 6 sets direction (`flags[8]`). The change is visible in the next cycle. Values 0 and 7 do nothing. No operation changes these three flags.
- R11: When `execEn` is low, or `opSel` is 5, 6 or 7, `result` and flags 0..5 keep their values.
- R12: After reset, `result` is 0 and all nine flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | Execute the operation on the inputs this cycle |
| opSel | input | 3 | Operation: 0 add, 1 subtract, 2 compare, 3 AND, 4 OR, 5..7 reserved |
| byteMode | input | 1 | 1 selects 8-bit operation on the low lane |
| opA | input | WORD_W | First operand |
| opB | input | WORD_W | Second operand |
| ctlCmd | input | 3 | Control-flag command (see R10) |
| result | output | WORD_W | Registered result |
| flags | output | 9 | {direction, interrupt, trap, overflow, sign, zero, aux, parity, carry}, bit 8 down to bit 0 |

## Verification
The bench builds the block with its default 16-bit word. Byte mode is swept over every value of A against sixteen evenly spread values of B for each of the five operations. The upper operand bits are filled with varying junk, so every low-nibble borrow, sign crossing and carry-out of the byte lane is reached. Word mode is run over a 64 × 64 grid of spread operands, which covers the 16-bit carry, borrow and overflow boundaries. Directed steps follow the sweeps and cover compare hold, the reserved opcodes, a low execute strobe and every control-flag command, with the control flags held set through operations.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;

  localparam int LANE_W = 8;
  localparam int FLAG_W = 9;

  // operation codes on opSel
  localparam logic [2:0] OP_ADD = 3'd0;
  localparam logic [2:0] OP_SUB = 3'd1;
  localparam logic [2:0] OP_CMP = 3'd2;
  localparam logic [2:0] OP_AND = 3'd3;
  localparam logic [2:0] OP_OR  = 3'd4;

  // control-flag commands on ctlCmd
  localparam logic [2:0] CMD_CLR_INT  = 3'd1;
  localparam logic [2:0] CMD_SET_INT  = 3'd2;
  localparam logic [2:0] CMD_CLR_TRAP = 3'd3;
  localparam logic [2:0] CMD_SET_TRAP = 3'd4;
  localparam logic [2:0] CMD_CLR_DIR  = 3'd5;
  localparam logic [2:0] CMD_SET_DIR  = 3'd6;

  // bit positions inside the flag vector
  localparam int FLG_CARRY = 0;
  localparam int FLG_PAR   = 1;
  localparam int FLG_AUX   = 2;
  localparam int FLG_ZERO  = 3;
  localparam int FLG_SIGN  = 4;
  localparam int FLG_OVF   = 5;
  localparam int FLG_TRAP  = 6;
  localparam int FLG_INT   = 7;
  localparam int FLG_DIR   = 8;

  typedef enum logic [1:0] {
    KIND_ADD = 2'd0,
    KIND_SUB = 2'd1,
    KIND_AND = 2'd2,
    KIND_OR  = 2'd3
  } aluKind_e;

  typedef struct packed {
    logic     loadResult;
    logic     loadStatus;
    aluKind_e kind;
    logic     byteSel;
    logic     setInt;
    logic     clrInt;
    logic     setTrap;
    logic     clrTrap;
    logic     setDir;
    logic     clrDir;
  } aluStrobe_t;

endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic       execEn,
  input  logic [2:0] opSel,
  input  logic       byteMode,
  input  logic [2:0] ctlCmd,
  output aluStrobe_t strobe
);

  logic opKnown;

  always_comb begin
    opKnown = 1'b1;
    strobe  = '0;
    unique case (opSel)
      OP_ADD:  strobe.kind = KIND_ADD;
      OP_SUB:  strobe.kind = KIND_SUB;
      OP_CMP:  strobe.kind = KIND_SUB;
      OP_AND:  strobe.kind = KIND_AND;
      OP_OR:   strobe.kind = KIND_OR;
      default: begin
        strobe.kind = KIND_ADD;
        opKnown     = 1'b0;     // reserved codes do nothing (R11)
      end
    endcase
    strobe.byteSel    = byteMode;
    strobe.loadStatus = execEn && opKnown;
    strobe.loadResult = execEn && opKnown && (opSel != OP_CMP);   // R3
    strobe.clrInt     = (ctlCmd == CMD_CLR_INT);
    strobe.setInt     = (ctlCmd == CMD_SET_INT);
    strobe.clrTrap    = (ctlCmd == CMD_CLR_TRAP);
    strobe.setTrap    = (ctlCmd == CMD_SET_TRAP);
    strobe.clrDir     = (ctlCmd == CMD_CLR_DIR);
    strobe.setDir     = (ctlCmd == CMD_SET_DIR);
  end

  AST_ONE_CTL_CMD: assert final ($countones({strobe.setInt, strobe.clrInt,
      strobe.setTrap, strobe.clrTrap, strobe.setDir, strobe.clrDir}) <= 1); // R10

endmodule

// File: rtl/alu_flag_datapath.sv
module alu_flag_datapath
  import alu_flag_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  aluStrobe_t        strobe,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  output logic [WORD_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  localparam int HIGH_W = WORD_W - LANE_W;

  logic [WORD_W-1:0] effA, effB, nextRes;
  logic [WORD_W:0]   wideOut;
  logic              signA, signB, signR;
  logic              nextCarry, nextAux, nextOvf, nextZero, nextSign, nextPar;
  logic              isArith;

  logic [WORD_W-1:0] resultQ;
  logic carryQ, parQ, auxQ, zeroQ, signQ, ovfQ;
  logic trapQ, intQ, dirQ;

  // byte mode: upper operand bits ignored (R9)
  assign effA = strobe.byteSel ? {{HIGH_W{1'b0}}, opA[LANE_W-1:0]} : opA;
  assign effB = strobe.byteSel ? {{HIGH_W{1'b0}}, opB[LANE_W-1:0]} : opB;

  assign isArith = (strobe.kind == KIND_ADD) || (strobe.kind == KIND_SUB);

  always_comb begin
    unique case (strobe.kind)
      KIND_ADD: wideOut = {1'b0, effA} + {1'b0, effB};
      KIND_SUB: wideOut = {1'b0, effA} - {1'b0, effB};
      KIND_AND: wideOut = {1'b0, effA & effB};
      default:  wideOut = {1'b0, effA | effB};
    endcase
  end

  always_comb begin
    if (strobe.byteSel) begin
      nextRes   = {{HIGH_W{1'b0}}, wideOut[LANE_W-1:0]};
      nextCarry = wideOut[LANE_W];
      signA     = effA[LANE_W-1];
      signB     = effB[LANE_W-1];
      signR     = wideOut[LANE_W-1];
    end else begin
      nextRes   = wideOut[WORD_W-1:0];
      nextCarry = wideOut[WORD_W];
      signA     = effA[WORD_W-1];
      signB     = effB[WORD_W-1];
      signR     = wideOut[WORD_W-1];
    end
    if (!isArith) nextCarry = 1'b0;                    // R4
    // carry or borrow across the bit 3 / bit 4 boundary (R7)
    nextAux = isArith && (effA[4] ^ effB[4] ^ wideOut[4]);
    // signed range (R8)
    if (strobe.kind == KIND_ADD)
      nextOvf = (signA == signB) && (signR != signA);
    else if (strobe.kind == KIND_SUB)
      nextOvf = (signA != signB) && (signR != signA);
    else
      nextOvf = 1'b0;
    nextZero = (nextRes == '0);                        // R5
    nextSign = signR;                                  // R5
    nextPar  = ~^nextRes[LANE_W-1:0];                  // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      resultQ <= '0;
    end else if (strobe.loadResult) begin
      resultQ <= nextRes;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      carryQ <= 1'b0;
      parQ   <= 1'b0;
      auxQ   <= 1'b0;
      zeroQ  <= 1'b0;
      signQ  <= 1'b0;
      ovfQ   <= 1'b0;
    end else if (strobe.loadStatus) begin
      carryQ <= nextCarry;
      parQ   <= nextPar;
      auxQ   <= nextAux;
      zeroQ  <= nextZero;
      signQ  <= nextSign;
      ovfQ   <= nextOvf;
    end
  end

  // control flags only move on their own commands (R10)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trapQ <= 1'b0;
      intQ  <= 1'b0;
      dirQ  <= 1'b0;
    end else begin
      if (strobe.setTrap)      trapQ <= 1'b1;
      else if (strobe.clrTrap) trapQ <= 1'b0;
      if (strobe.setInt)       intQ  <= 1'b1;
      else if (strobe.clrInt)  intQ  <= 1'b0;
      if (strobe.setDir)       dirQ  <= 1'b1;
      else if (strobe.clrDir)  dirQ  <= 1'b0;
    end
  end

  assign result = resultQ;

  always_comb begin
    flags            = '0;
    flags[FLG_CARRY] = carryQ;
    flags[FLG_PAR]   = parQ;
    flags[FLG_AUX]   = auxQ;
    flags[FLG_ZERO]  = zeroQ;
    flags[FLG_SIGN]  = signQ;
    flags[FLG_OVF]   = ovfQ;
    flags[FLG_TRAP]  = trapQ;
    flags[FLG_INT]   = intQ;
    flags[FLG_DIR]   = dirQ;
  end

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadResult) |=> (zeroQ == (resultQ == '0))); // R5

  AST_PARITY_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadResult) |=> (parQ == ~^resultQ[LANE_W-1:0])); // R6

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadStatus && !isArith) |=> (!carryQ && !auxQ && !ovfQ)); // R4

  AST_BYTE_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.loadResult && strobe.byteSel) |=> (resultQ[WORD_W-1:LANE_W] == '0)); // R9

  AST_INT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.setInt |=> intQ); // R10

  AST_INT_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    strobe.clrInt |=> !intQ); // R10

  AST_CTL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(strobe.setInt || strobe.clrInt || strobe.setTrap || strobe.clrTrap ||
      strobe.setDir || strobe.clrDir) |=> $stable({trapQ, intQ, dirQ})); // R10

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.loadStatus |=> $stable({carryQ, parQ, auxQ, zeroQ, signQ, ovfQ, resultQ})); // R11

endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              execEn,
  input  logic [2:0]        opSel,
  input  logic              byteMode,
  input  logic [WORD_W-1:0] opA,
  input  logic [WORD_W-1:0] opB,
  input  logic [2:0]        ctlCmd,
  output logic [WORD_W-1:0] result,
  output logic [FLAG_W-1:0] flags
);

  aluStrobe_t strobe;

  alu_flag_ctrl u_ctrl (
    .execEn   (execEn),
    .opSel    (opSel),
    .byteMode (byteMode),
    .ctlCmd   (ctlCmd),
    .strobe   (strobe)
  );

  alu_flag_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (strobe),
    .opA    (opA),
    .opB    (opB),
    .result (result),
    .flags  (flags)
  );

  AST_CMP_KEEPS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    (execEn && opSel == OP_CMP) |=> $stable(result)); // R3

endmodule

// File: tb/alu_flag_unit_bench.sv
module alu_flag_unit_bench;

  localparam int WORD_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              execEn = 1'b0;
  logic [2:0]        opSel = 3'd0;
  logic              byteMode = 1'b0;
  logic [WORD_W-1:0] opA = '0;
  logic [WORD_W-1:0] opB = '0;
  logic [2:0]        ctlCmd = 3'd0;
  logic [WORD_W-1:0] result;
  logic [8:0]        flags;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  finished = 1'b0;

  // expected state
  int  expRes = 0;
  bit  eC, eP, eA, eZ, eS, eO, eT, eI, eD;

  always #2.5 clk = ~clk;

  alu_flag_unit #(.WORD_W(WORD_W)) u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .execEn(execEn), .opSel(opSel),
    .byteMode(byteMode), .opA(opA), .opB(opB), .ctlCmd(ctlCmd),
    .result(result), .flags(flags)
  );

  function automatic logic [8:0] expFlags();
    return {eD, eI, eT, eO, eS, eZ, eA, eP, eC};
  endfunction

  task automatic compare(input string tag);
    nChecks++;
    if (result !== expRes[WORD_W-1:0] || flags !== expFlags()) begin
      nFails++;
      $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
               tag, result, flags, expRes[WORD_W-1:0], expFlags());
    end
  endtask

  // one operation; caller is at a negedge
  task automatic runOp(input int op, input bit bm, input int a, input int b, input string tag);
    int w, md, ea, eb, r, sa, sb, sr;
    w  = bm ? 8 : WORD_W;
    md = 1 << w;
    ea = a & (md - 1);
    eb = b & (md - 1);
    r  = 0;
    sa = (ea >> (w - 1)) & 1;
    sb = (eb >> (w - 1)) & 1;
    case (op)
      0: begin
        r  = (ea + eb) % md;
        eC = (ea + eb) >= md;
        eA = ((ea & 15) + (eb & 15)) > 15;
        sr = (r >> (w - 1)) & 1;
        eO = (sa == sb) && (sr != sa);
      end
      1, 2: begin
        r  = (ea - eb + md) % md;
        eC = ea < eb;
        eA = (ea & 15) < (eb & 15);
        sr = (r >> (w - 1)) & 1;
        eO = (sa != sb) && (sr != sa);
      end
      default: begin
        r  = (op == 3) ? (ea & eb) : (ea | eb);
        eC = 0; eA = 0; eO = 0;
      end
    endcase
    eZ = (r == 0);
    eS = (r >> (w - 1)) & 1;
    eP = ($countones(r & 255) % 2) == 0;
    if (op != 2) expRes = r;
    execEn = 1'b1; opSel = op[2:0]; byteMode = bm;
    opA = a[WORD_W-1:0]; opB = b[WORD_W-1:0]; ctlCmd = 3'd0;
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  // a cycle expected to change nothing but the control flags
  task automatic runIdle(input bit ex, input int op, input int cmd, input string tag);
    execEn = ex; opSel = op[2:0]; byteMode = 1'b0;
    opA = 16'h1234; opB = 16'h4321; ctlCmd = cmd[2:0];
    case (cmd)
      1: eI = 0; 2: eI = 1; 3: eT = 0; 4: eT = 1; 5: eD = 0; 6: eD = 1;
      default: ;
    endcase
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  function automatic string opTag(input int op);
    case (op)
      0: return "R1 add";
      1: return "R2 sub";
      2: return "R3 cmp";
      default: return "R4 logic";
    endcase
  endfunction

  initial begin
    {eC, eP, eA, eZ, eS, eO, eT, eI, eD} = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R12 reset");

    // directed corners
    runOp(0, 1, 255, 1, "R1 byte 255+1 carry");
    runOp(1, 1, 3, 3, "R5 zero from 3-3");
    runOp(0, 1, 16'h0F, 16'h01, "R7 aux carry");
    runOp(0, 1, 16'h7F, 16'h01, "R8 byte overflow");
    runOp(1, 0, 16'h8000, 16'h0001, "R8 word overflow");
    runOp(0, 0, 16'h00FF, 16'h0100, "R6 parity low lane");
    runOp(0, 1, 16'hAB12, 16'hCD34, "R9 byte ignores upper");

    // control flags set, held through operations (R10)
    runIdle(0, 0, 2, "R10 set int");
    runIdle(0, 0, 4, "R10 set trap");
    runIdle(0, 0, 6, "R10 set dir");
    runIdle(0, 0, 7, "R10 cmd 7 no effect");

    // byte sweep: every A against 16 values of B, junk in upper bits (R9)
    for (int op = 0; op < 5; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          runOp(op, 1, a | (((a * 37 + k) & 255) << 8),
                ((k * 17 + a) & 255) | (((k * 91) & 255) << 8), opTag(op));

    // word sweep over a spread grid
    for (int op = 0; op < 5; op++)
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          runOp(op, 0, (i * 4099 + 1) & 65535, (j * 1031 + 32767 * (j & 1)) & 65535, opTag(op));

    // compare must hold the result (R3)
    runOp(0, 0, 16'h1111, 16'h2222, "R1 seed");
    runOp(2, 0, 16'h0005, 16'h0009, "R3 cmp hold");

    // no execute and reserved codes (R11)
    runIdle(0, 0, 0, "R11 exec low");
    runIdle(1, 5, 0, "R11 opcode 5");
    runIdle(1, 6, 0, "R11 opcode 6");
    runIdle(1, 7, 0, "R11 opcode 7");

    // clearing commands (R10)
    runIdle(0, 0, 1, "R10 clr int");
    runIdle(0, 0, 3, "R10 clr trap");
    runIdle(0, 0, 5, "R10 clr dir");
    runOp(4, 0, 16'h00F0, 16'h0F00, "R10 op leaves ctl clear");

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

endmodule